// File: doc/BRIEF.md
# Conversion-Triggered SPI Read-Burst Generator

This block lets a multi-channel ADC push each finished sample frame into a host whose SPI port waits in slave mode with DMA armed. When the ADC raises its conversion-complete flag, the block drives chip-select low. It then produces a serial clock from a programmable divider of the system clock, so the frame shifts out of the ADC and straight into the host. No host command starts the transfer.

A burst ends in one of two ways. In count mode it ends after a fixed number of clock pulses (64 by default: four 16-bit channels). In flag mode it ends once the ADC drops its flag. The block marks every 16-bit boundary so the host DMA can finish each unit in time. A flag that rises again while a burst is still running is treated as an overrun.

The block also steers the data lines. In configuration mode the host runs the bus as master. In streaming mode the ADC output goes to the host's slave input and the block drives the clock.

Top module: `conv_burst_ctrl`

## Requirements
- R1: With `route_stream_i`=1, `route_cfg_i`=0, no overrun and no burst running, a rising `cnv_i` pulls chip-select low on the third rising `clk` edge after the change. A `cnv_i` held high starts only one burst.
- R2: With `flag_mode_i`=0 (count mode), every burst contains exactly 64 rising serial-clock edges.
- R3: The serial clock stays low outside a burst. Each high phase and each low phase lasts H system cycles, where H is `div_half_i`, or 1 when `div_half_i` is 0.
- R4: Chip-select falls H cycles before the first rising serial-clock edge and rises H cycles after the last falling edge.
- R5: With `flag_mode_i`=1 (flag mode), the burst stops at the end of the first low phase that sees the synchronized flag low. After the flag falls there is at most one more rising clock edge, and chip-select is high within 2H+4 cycles.
- R6: `word_mark_o` is a one-cycle pulse that coincides with the falling serial-clock edge ending pulse 16, 32, 48 and so on. A count-mode burst therefore gives 4 marks.
- R7: A rising `cnv_i` during a burst sets `overrun_o`, and the running burst still completes normally. While `overrun_o` is set, rising flags start no burst. `ovr_clr_i` clears the flag.
- R8: `busy_o` is high exactly while the generated chip-select is low. `done_o` is high for one cycle, on the same edge that chip-select rises.
- R9: With `route_cfg_i`=1 and `route_stream_i`=0, the ADC clock, data-in and chip-select follow `host_sck_i`, `host_mo_i` and `host_cs_n_i`, and `host_mi_o` follows `adc_dout_i`. With streaming selected, `host_si_o` follows `adc_dout_i`, and the ADC and host clock and chip-select are the generated ones.
- R10: Outside streaming mode (`route_stream_i`=0, or both mode inputs 1), a rising `cnv_i` starts no burst. The generated clock and chip-select outputs stay idle, and with both mode inputs set the ADC chip-select is high.
- R11: The half-period is captured at burst start. Changing `div_half_i` during a burst does not alter that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_i | input | 1 | Asynchronous conversion-complete flag from the ADC, active high |
| flag_mode_i | input | 1 | 0: stop after a fixed count; 1: stop when the flag drops |
| div_half_i | input | 8 | Serial-clock half-period in system cycles (0 treated as 1) |
| route_stream_i | input | 1 | Streaming routing select |
| route_cfg_i | input | 1 | Configuration routing select |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| host_sck_i | input | 1 | Host master clock (configuration) |
| host_mo_i | input | 1 | Host master-out data (configuration) |
| host_cs_n_i | input | 1 | Host chip-select (configuration) |
| adc_dout_i | input | 1 | ADC serial data output |
| adc_sclk_o | output | 1 | Serial clock to the ADC |
| adc_din_o | output | 1 | Serial data to the ADC |
| adc_cs_n_o | output | 1 | Chip-select to the ADC |
| host_mi_o | output | 1 | Host master-in data |
| host_si_o | output | 1 | Host slave-in data |
| host_sck_o | output | 1 | Generated clock to the host slave port |
| host_cs_n_o | output | 1 | Generated chip-select to the host slave port |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| word_mark_o | output | 1 | One-cycle pulse at each 16-bit boundary |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Chip-select is due three rising edges after the flag changes. The first clock rise comes H cycles after that, each phase lasts H cycles, and the release comes H cycles after the final fall. The flag-mode stop falls due within 2H+4 cycles of the flag dropping. The bench drives inputs at the falling clock edge and samples at the next falling edge. It counts those edges from the stimulus and from each serial-clock transition, and compares the counts with H values and pulse totals that it derives itself. The routing paths are combinational, so they are compared in the same sample as the stimulus. The done, mark and busy outputs are checked in the same sample as the chip-select or clock transition they accompany.

// File: rtl/cb_pkg.sv
// Shared types for the conversion-triggered burst generator.
package cb_pkg;
    // Burst sequencer phases: idle, chip-select lead-in, clock high, clock low.
    typedef enum logic [1:0] {
        CB_IDLE = 2'd0,
        CB_LEAD = 2'd1,
        CB_HIGH = 2'd2,
        CB_LOW  = 2'd3
    } cb_state_t;
endpackage

// File: rtl/cb_sync_edge.sv
// Synchronizes an asynchronous level through STAGES flops and flags its
// rising edge for one cycle. Assumes STAGES >= 2.
module cb_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw level through the synchronizer and keep the last output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cb_overrun.sv
// Sticky overrun flag: set when a new conversion edge arrives mid-burst,
// cleared by the host. Setting wins over clearing in the same cycle.
module cb_overrun (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic busy_i,
    input  logic clr_i,
    output logic ovr_o
);
    // Hold the overrun condition until it is explicitly cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr_o <= 1'b0;
        else if (rise_i && busy_i) ovr_o <= 1'b1;
        else if (clr_i)            ovr_o <= 1'b0;
    end
endmodule

// File: rtl/cb_burst_fsm.sv
// Generates one chip-select window and serial-clock burst per start pulse.
// The half-period is captured at start. The burst ends after BURST_LEN
// pulses (count mode) or when the synchronized flag is low at the end of a
// low phase (flag mode). Word marks fall on every 2**WORD_LOG2-th falling edge.
module cb_burst_fsm
    import cb_pkg::*;
#(
    parameter int BURST_LEN = 64,
    parameter int DIV_W     = 8,
    parameter int WORD_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             flag_mode_i,
    input  logic             flag_lvl_i,
    input  logic [DIV_W-1:0] div_half_i,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             mark_o
);
    localparam int PC_NEED = $clog2(BURST_LEN + 1);
    localparam int CNT_W   = (PC_NEED > WORD_LOG2) ? PC_NEED : WORD_LOG2 + 1;

    cb_state_t        state;
    logic [DIV_W-1:0] hc;
    logic [DIV_W-1:0] hlat;
    logic [CNT_W-1:0] pc;
    logic [DIV_W-1:0] h_eff;
    logic             stop;

    // Clamp a zero divider to the shortest legal half-period.
    assign h_eff = (div_half_i == '0) ? DIV_W'(1) : div_half_i;
    // End-of-burst decision taken at the end of each low phase.
    assign stop  = flag_mode_i ? ~flag_lvl_i : (pc == CNT_W'(BURST_LEN));

    // Sequence lead-in, clock phases and release with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CB_IDLE;
            sclk_o <= 1'b0;
            cs_n_o <= 1'b1;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            mark_o <= 1'b0;
            hc     <= '0;
            hlat   <= DIV_W'(1);
            pc     <= '0;
        end else begin
            done_o <= 1'b0;
            mark_o <= 1'b0;
            case (state)
                CB_IDLE: begin
                    if (start_i) begin
                        state  <= CB_LEAD;
                        cs_n_o <= 1'b0;
                        busy_o <= 1'b1;
                        hlat   <= h_eff;
                        hc     <= h_eff - DIV_W'(1);
                        pc     <= '0;
                    end
                end
                CB_LEAD: begin
                    if (hc == '0) begin
                        state  <= CB_HIGH;
                        sclk_o <= 1'b1;
                        hc     <= hlat - DIV_W'(1);
                        pc     <= pc + CNT_W'(1);
                    end else begin
                        hc <= hc - DIV_W'(1);
                    end
                end
                CB_HIGH: begin
                    if (hc == '0) begin
                        state  <= CB_LOW;
                        sclk_o <= 1'b0;
                        hc     <= hlat - DIV_W'(1);
                        mark_o <= (pc[WORD_LOG2-1:0] == '0);
                    end else begin
                        hc <= hc - DIV_W'(1);
                    end
                end
                CB_LOW: begin
                    if (hc == '0) begin
                        if (stop) begin
                            state  <= CB_IDLE;
                            cs_n_o <= 1'b1;
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                        end else begin
                            state  <= CB_HIGH;
                            sclk_o <= 1'b1;
                            hc     <= hlat - DIV_W'(1);
                            pc     <= pc + CNT_W'(1);
                        end
                    end else begin
                        hc <= hc - DIV_W'(1);
                    end
                end
                default: state <= CB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cb_route.sv
// Data-line steering between host and ADC. Configuration mode lets the host
// master the bus; streaming mode routes ADC data to the host slave input and
// uses the generated clock and chip-select. Any other combination is idle.
module cb_route (
    input  logic route_stream_i,
    input  logic route_cfg_i,
    input  logic gen_sclk_i,
    input  logic gen_cs_n_i,
    input  logic host_sck_i,
    input  logic host_mo_i,
    input  logic host_cs_n_i,
    input  logic adc_dout_i,
    output logic stream_on_o,
    output logic adc_sclk_o,
    output logic adc_din_o,
    output logic adc_cs_n_o,
    output logic host_mi_o,
    output logic host_si_o,
    output logic host_sck_o,
    output logic host_cs_n_o
);
    logic cfg_on;

    // Decode the two mode inputs and select each line's source.
    always_comb begin
        cfg_on      = route_cfg_i & ~route_stream_i;
        stream_on_o = route_stream_i & ~route_cfg_i;
        adc_sclk_o  = cfg_on ? host_sck_i  : (stream_on_o ? gen_sclk_i : 1'b0);
        adc_cs_n_o  = cfg_on ? host_cs_n_i : (stream_on_o ? gen_cs_n_i : 1'b1);
        adc_din_o   = cfg_on & host_mo_i;
        host_mi_o   = cfg_on & adc_dout_i;
        host_si_o   = stream_on_o & adc_dout_i;
        host_sck_o  = stream_on_o & gen_sclk_i;
        host_cs_n_o = stream_on_o ? gen_cs_n_i : 1'b1;
    end
endmodule

// File: rtl/conv_burst_ctrl.sv
// Top level: turns each new conversion-complete flag into an SPI read burst
// into a slave-mode host, and steers data lines for host configuration
// access. Assumes cnv_i is asynchronous and stays low between frames for at
// least a few system cycles.
module conv_burst_ctrl #(
    parameter int BURST_LEN   = 64,
    parameter int DIV_W       = 8,
    parameter int WORD_LOG2   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv_i,
    input  logic             flag_mode_i,
    input  logic [DIV_W-1:0] div_half_i,
    input  logic             route_stream_i,
    input  logic             route_cfg_i,
    input  logic             ovr_clr_i,
    input  logic             host_sck_i,
    input  logic             host_mo_i,
    input  logic             host_cs_n_i,
    input  logic             adc_dout_i,
    output logic             adc_sclk_o,
    output logic             adc_din_o,
    output logic             adc_cs_n_o,
    output logic             host_mi_o,
    output logic             host_si_o,
    output logic             host_sck_o,
    output logic             host_cs_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             word_mark_o,
    output logic             overrun_o
);
    logic flag_lvl;
    logic flag_rise;
    logic stream_on;
    logic start;
    logic gen_sclk;
    logic gen_cs_n;

    cb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cnv_i),
        .level_o (flag_lvl),
        .rise_o  (flag_rise)
    );

    cb_overrun u_ovr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (flag_rise),
        .busy_i (busy_o),
        .clr_i  (ovr_clr_i),
        .ovr_o  (overrun_o)
    );

    // A burst may start only on a fresh edge, in streaming mode, when idle and clean.
    assign start = flag_rise & stream_on & ~busy_o & ~overrun_o;

    cb_burst_fsm #(
        .BURST_LEN (BURST_LEN),
        .DIV_W     (DIV_W),
        .WORD_LOG2 (WORD_LOG2)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .flag_mode_i (flag_mode_i),
        .flag_lvl_i  (flag_lvl),
        .div_half_i  (div_half_i),
        .sclk_o      (gen_sclk),
        .cs_n_o      (gen_cs_n),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .mark_o      (word_mark_o)
    );

    cb_route u_route (
        .route_stream_i (route_stream_i),
        .route_cfg_i    (route_cfg_i),
        .gen_sclk_i     (gen_sclk),
        .gen_cs_n_i     (gen_cs_n),
        .host_sck_i     (host_sck_i),
        .host_mo_i      (host_mo_i),
        .host_cs_n_i    (host_cs_n_i),
        .adc_dout_i     (adc_dout_i),
        .stream_on_o    (stream_on),
        .adc_sclk_o     (adc_sclk_o),
        .adc_din_o      (adc_din_o),
        .adc_cs_n_o     (adc_cs_n_o),
        .host_mi_o      (host_mi_o),
        .host_si_o      (host_si_o),
        .host_sck_o     (host_sck_o),
        .host_cs_n_o    (host_cs_n_o)
    );
endmodule

// File: rtl/conv_burst_ctrl_chk.sv
// Temporal checks on the burst generator, bound into every instance.
module conv_burst_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic word_mark_o,
    input logic overrun_o,
    input logic ovr_clr_i,
    input logic gen_sclk,
    input logic gen_cs_n
);
    // R3: the serial clock is idle low whenever no burst is active.
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !gen_sclk);

    // R4: every rising serial-clock edge happens inside the chip-select window.
    a_r4_rise_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_sclk) |-> !gen_cs_n);

    // R8: busy tracks the chip-select window.
    a_r8_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == !gen_cs_n);

    // R8: done lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done coincides with chip-select release.
    a_r8_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(gen_cs_n));

    // R6: a word mark only appears on a falling serial-clock edge.
    a_r6_mark_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        word_mark_o |-> $fell(gen_sclk));

    // R7: overrun holds until cleared.
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovr_clr_i) |=> overrun_o);
endmodule

bind conv_burst_ctrl conv_burst_ctrl_chk u_chk (.*);

// File: tb/conv_burst_ctrl_bench.sv
// Self-checking bench: directed corners plus seeded random bursts.
module conv_burst_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnv_i = 1'b0;
    logic       flag_mode_i = 1'b0;
    logic [7:0] div_half_i = 8'd1;
    logic       route_stream_i = 1'b1;
    logic       route_cfg_i = 1'b0;
    logic       ovr_clr_i = 1'b0;
    logic       host_sck_i = 1'b0;
    logic       host_mo_i = 1'b0;
    logic       host_cs_n_i = 1'b1;
    logic       adc_dout_i = 1'b0;
    logic adc_sclk_o, adc_din_o, adc_cs_n_o, host_mi_o, host_si_o;
    logic host_sck_o, host_cs_n_o, busy_o, done_o, word_mark_o, overrun_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    conv_burst_ctrl u_conv_burst_ctrl (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Effective half-period from the divider setting (R3).
    function automatic int half_of(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    // Number of word marks a burst of n pulses should carry (R6).
    function automatic int marks_of(input int n);
        return n / 16;
    endfunction

    // Run one streaming burst and check its shape.
    task automatic do_burst(input int d, input bit fmode, input int drop_at, input bit bounce);
        int h, lat, t, rises, marks, first_rise, last_fall, hstart, lstart;
        int wid_err, mark_err, side_err, rd, td;
        bit ps;
        h = half_of(d);
        div_half_i  = 8'(d);
        flag_mode_i = fmode;
        repeat (2) @(negedge clk);
        cnv_i = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (host_cs_n_o && lat < 20);
        chk(lat == 3, "R1 start latency", lat, 3);
        t = 0; ps = 1'b0; rises = 0; marks = 0; first_rise = 0; last_fall = 0;
        hstart = 0; lstart = 0; wid_err = 0; mark_err = 0; side_err = 0; rd = 0; td = 0;
        while (!host_cs_n_o && t < 4000) begin
            if (host_sck_o && !ps) begin
                rises++;
                if (rises == 1) first_rise = t;
                else if (t - lstart != h) wid_err++;
                hstart = t;
                if (rises == 2) div_half_i = 8'($urandom_range(0, 6));
                if (fmode && rises == drop_at) begin
                    cnv_i = 1'b0; rd = rises; td = t;
                end
                if (bounce && rises == 5)  cnv_i = 1'b0;
                if (bounce && rises == 10) cnv_i = 1'b1;
            end
            if (!host_sck_o && ps) begin
                if (t - hstart != h) wid_err++;
                lstart = t;
                last_fall = t;
            end
            if (word_mark_o) begin
                marks++;
                if (host_sck_o || !ps) mark_err++;
            end
            if (done_o || !busy_o) side_err++;
            if (host_si_o != adc_dout_i || adc_sclk_o != host_sck_o ||
                adc_cs_n_o != host_cs_n_o || host_mi_o || adc_din_o) side_err++;
            ps = host_sck_o;
            adc_dout_i = 1'($urandom);
            @(negedge clk);
            t++;
        end
        chk(h == first_rise, "R4 lead-in", first_rise, h);
        chk(t - last_fall == h, "R4 tail", t - last_fall, h);
        chk(wid_err == 0, "R3/R11 phase widths", wid_err, 0);
        chk(side_err == 0, "R8/R9 busy and streaming route", side_err, 0);
        chk(mark_err == 0, "R6 mark on falling edge", mark_err, 0);
        chk(marks == marks_of(rises), "R6 mark count", marks, marks_of(rises));
        if (!fmode) begin
            chk(rises == 64, "R2 pulse count", rises, 64);
        end else begin
            chk(rises - rd <= 1, "R5 extra pulses after drop", rises - rd, 1);
            chk(t - td <= 2 * h + 4, "R5 stop delay", t - td, 2 * h + 4);
        end
        chk(done_o && !busy_o, "R8 done at release", int'(done_o), 1);
        @(negedge clk);
        chk(!done_o, "R8 done width", int'(done_o), 0);
        if (!fmode) begin
            int stray = 0;
            repeat (20) begin
                @(negedge clk);
                if (!host_cs_n_o) stray++;
            end
            chk(stray == 0, "R1 held flag no retrigger", stray, 0);
            cnv_i = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_cs_n_o && !host_sck_o, "R3 reset idle", int'(host_sck_o), 0);
        chk(!busy_o && !done_o, "R8 reset busy/done", int'(busy_o), 0);
        chk(!overrun_o, "R7 reset overrun", int'(overrun_o), 0);

        // Directed corners.
        do_burst(1, 1'b0, 0, 1'b0);
        do_burst(0, 1'b0, 0, 1'b0);
        do_burst(4, 1'b1, 20, 1'b0);
        do_burst(1, 1'b1, 3, 1'b0);

        // Seeded random bursts.
        void'($urandom(32'd1234));
        for (int i = 0; i < 12; i++) begin
            do_burst($urandom_range(0, 6), 1'($urandom), $urandom_range(3, 70), 1'b0);
        end

        // R7: overrun during a burst, then blocking and clearing.
        do_burst(2, 1'b0, 0, 1'b1);
        chk(overrun_o, "R7 overrun set", int'(overrun_o), 1);
        cnv_i = 1'b1;
        begin
            int stray = 0;
            repeat (30) begin
                @(negedge clk);
                if (!host_cs_n_o) stray++;
            end
            chk(stray == 0, "R7 blocked while overrun", stray, 0);
        end
        cnv_i = 1'b0;
        ovr_clr_i = 1'b1;
        @(negedge clk);
        ovr_clr_i = 1'b0;
        @(negedge clk);
        chk(!overrun_o, "R7 overrun cleared", int'(overrun_o), 0);
        do_burst(2, 1'b0, 0, 1'b0);

        // R9: configuration routing.
        route_stream_i = 1'b0;
        route_cfg_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            logic [3:0] v;
            v = 4'($urandom);
            host_sck_i = v[0]; host_mo_i = v[1]; host_cs_n_i = v[2]; adc_dout_i = v[3];
            #1;
            chk(adc_sclk_o == v[0] && adc_din_o == v[1] && adc_cs_n_o == v[2] &&
                host_mi_o == v[3], "R9 config route", int'({adc_cs_n_o, adc_din_o, adc_sclk_o}),
                int'(v[2:0]));
            chk(!host_si_o && !host_sck_o && host_cs_n_o, "R9 slave side idle in config",
                int'(host_sck_o), 0);
            @(negedge clk);
        end

        // R10: flag edges outside streaming mode start nothing.
        cnv_i = 1'b1;
        begin
            int stray = 0;
            repeat (12) begin
                @(negedge clk);
                if (busy_o || !host_cs_n_o || host_sck_o) stray++;
            end
            chk(stray == 0, "R10 no burst in config mode", stray, 0);
        end
        cnv_i = 1'b0;
        repeat (4) @(negedge clk);
        route_stream_i = 1'b1;
        host_cs_n_i = 1'b0;
        cnv_i = 1'b1;
        begin
            int stray = 0;
            repeat (12) begin
                @(negedge clk);
                if (busy_o || !adc_cs_n_o || adc_sclk_o) stray++;
            end
            chk(stray == 0, "R10 no burst with both modes set", stray, 0);
        end
        cnv_i = 1'b0;
        route_cfg_i = 1'b0;
        repeat (4) @(negedge clk);
        do_burst(3, 1'b0, 0, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule